// File: doc/BRIEF.md
# Timer, Watchdog and Bus-Surveillance Unit

This block holds six memory-mapped down-counters behind one register port. Four of them are general-purpose timers. Two of these advance only on cycles that carry a half-rate enable tick. The other two advance on every clock. Each general-purpose timer either stops after one expiry or reloads and keeps running.

The fifth counter is a watchdog. Its first expiry raises an interrupt. If that interrupt is still pending when the watchdog expires again, the block asserts a CPU reset request for a fixed number of cycles.

The sixth counter watches bus accesses. It is reloaded at the start of each access and counts while an access is outstanding. If it reaches its end before the access completes, it reports a bus error.

Every counter sets a sticky status bit when it expires, and that bit can drive an interrupt line. Software clears status bits by writing ones to them.

Top module: `timer_wdog_unit`

## Requirements
- R1: After reset, every count, reload, control bit and status bit is zero, and `irq`, `cpu_rst` and `bus_err` are low.
- R2: `addr[4:2]` selects the timer, numbered 0 to 5, and `addr[1:0]` selects its register. Register 0 is control, with enable in bit 0, continuous mode in bit 1 and interrupt enable in bit 2. Register 1 is reload, and a write to it also loads the count. Register 2 is the read-only count. Address 5'b11100 is the status register, with timer i in bit i. Every other address reads zero. `rdata` is combinational from `addr`.
- R3: Timers 0 and 1 advance only on clock edges where `half_tick` is high. Timers 2, 3 and 4 advance on every edge while enabled.
- R4: A timer expires when it advances with a count of 1 or 0. A general-purpose timer in continuous mode then reloads its count from the reload register and sets its status bit.
- R5: A general-purpose timer in one-shot mode that expires sets its count to 0, clears its enable bit and sets its status bit.
- R6: Status bits are sticky. A status write clears each bit written as one, and a set in the same cycle wins over the clear. `irq[i]` equals status bit i AND the interrupt-enable bit of timer i.
- R7: The watchdog (timer 4) always reloads on expiry and ignores the mode bit. An expiry while status bit 4 is clear sets that bit. An expiry while status bit 4 is already set raises `cpu_rst` from the next edge for RST_LEN cycles.
- R8: Clearing status bit 4 services the watchdog, so the following expiry only sets the bit again and does not raise `cpu_rst`.
- R9: For the surveillance timer (timer 5), `acc_start` loads the count from reload and marks an access outstanding. `acc_done` ends the outstanding access and freezes the count. If both arrive together, `acc_start` wins. The timer advances only while enabled and an access is outstanding.
- R10: If the surveillance timer expires with neither `acc_start` nor `acc_done` present, it sets status bit 5, sets its count to 0, ends the outstanding access and drives `bus_err` high for exactly one cycle after that edge.
- R11: A register write to a timer in the same cycle as that timer's own count update takes effect over the count update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Enable for timers 0 and 1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data |
| irq | output | 6 | Per-timer interrupt lines |
| cpu_rst | output | 1 | CPU reset request pulse |
| acc_start | input | 1 | A bus access has begun |
| acc_done | input | 1 | The outstanding bus access has completed |
| bus_err | output | 1 | Bus error on access timeout |

## Verification
A wrong count shows first on the count register, in the cycle after the faulty edge. It also moves the next expiry, so a status or interrupt edge falls one or more cycles early or late. A watchdog first-expiry flag that is set or cleared wrongly shows as a reset pulse that is missing or unwanted at the second expiry, within one watchdog period. A surveillance outstanding flag that is stuck shows as a spurious `bus_err` or a missing one, at the end of the current access window. The bench compares every output and the addressed register on every cycle, so each such fault is reported in the cycle it first becomes visible.

// File: rtl/timer_wdog_unit.sv
module timer_wdog_unit #(
  parameter int CW      = 16,
  parameter int RST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_tick,
  input  logic          wr_en,
  input  logic [4:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [5:0]    irq,
  output logic          cpu_rst,
  input  logic          acc_start,
  input  logic          acc_done,
  output logic          bus_err
);
  localparam int NT = 6;
  localparam int RW = $clog2(RST_LEN + 1);

  logic [CW-1:0] cnt [NT];
  logic [CW-1:0] rld [NT];
  logic [NT-1:0] en, md, ie, st;
  logic [NT-1:0] adv, hit, set_st;
  logic          busy, berr, sv_exp, wd_fire, stw;
  logic [RW-1:0] rcnt;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      if (i < 2)       adv[i] = en[i] & half_tick;
      else if (i == 5) adv[i] = en[i] & busy;
      else             adv[i] = en[i];
      hit[i] = adv[i] && (cnt[i] <= CW'(1));
    end
  end

  assign sv_exp  = hit[5] & ~acc_start & ~acc_done;
  assign wd_fire = hit[4] & st[4];
  assign stw     = wr_en && (addr == 5'b11100);
  assign set_st  = {sv_exp, hit[4:0]};
  assign irq     = st & ie;
  assign cpu_rst = (rcnt != '0);
  assign bus_err = berr;

  always_comb begin
    rdata = '0;
    if (addr == 5'b11100) rdata = CW'(st);
    else if (addr[4:2] < 3'd6) begin
      case (addr[1:0])
        2'd0:    rdata = CW'({ie[addr[4:2]], md[addr[4:2]], en[addr[4:2]]});
        2'd1:    rdata = rld[addr[4:2]];
        2'd2:    rdata = cnt[addr[4:2]];
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        cnt[i] <= '0;
        rld[i] <= '0;
      end
      en <= '0; md <= '0; ie <= '0; st <= '0;
      busy <= 1'b0; berr <= 1'b0; rcnt <= '0;
    end else begin
      berr <= sv_exp;
      if (wd_fire)           rcnt <= RW'(RST_LEN);
      else if (rcnt != '0)   rcnt <= rcnt - 1'b1;
      if (acc_start)                busy <= 1'b1;
      else if (acc_done || sv_exp)  busy <= 1'b0;
      st <= (st & ~(stw ? wdata[NT-1:0] : '0)) | set_st;
      for (int i = 0; i < NT; i++) begin
        if (i == 5 && acc_start) cnt[i] <= rld[i];
        else if (adv[i] && !(i == 5 && acc_done)) begin
          if (!hit[i])                      cnt[i] <= cnt[i] - 1'b1;
          else if (i == 4 || (i < 4 && md[i])) cnt[i] <= rld[i];
          else begin
            cnt[i] <= '0;
            if (i < 4) en[i] <= 1'b0;
          end
        end
        if (wr_en && addr[4:2] == 3'(i)) begin
          if (addr[1:0] == 2'd0) begin
            en[i] <= wdata[0]; md[i] <= wdata[1]; ie[i] <= wdata[2];
          end else if (addr[1:0] == 2'd1) begin
            rld[i] <= wdata; cnt[i] <= wdata;
          end
        end
      end
    end
  end

  p_slow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(half_tick) && !$past(wr_en)) |-> $stable(cnt[0]));
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en[2]) |-> ($past(wr_en) || st[2]));
  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st[0]) |-> $past(stw && wdata[0]));
  p_reset_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> st[4]);
  p_idle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(acc_start) && !$past(wr_en)) |-> $stable(cnt[5]));
  p_berr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);
  p_berr_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> st[5]);
endmodule

// File: tb/timer_wdog_unit_test.sv
module timer_wdog_unit_test;
  localparam int CW = 16;
  localparam int RST_LEN = 4;

  logic clk = 0, rst_n = 0, half_tick = 0, wr_en = 0, acc_start = 0, acc_done = 0;
  logic [4:0] addr = 0;
  logic [CW-1:0] wdata = 0, rdata;
  logic [5:0] irq;
  logic cpu_rst, bus_err;

  timer_wdog_unit #(.CW(CW), .RST_LEN(RST_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .cpu_rst(cpu_rst),
    .acc_start(acc_start), .acc_done(acc_done), .bus_err(bus_err));

  always #5 clk = ~clk;

  int vecs = 0, bad = 0;
  string req = "R1";
  int m_cnt[6], m_rld[6];
  bit m_en[6], m_md[6], m_ie[6], m_st[6];
  bit m_busy, m_berr;
  int m_rc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        m_cnt[i] = 0; m_rld[i] = 0; m_en[i] = 0; m_md[i] = 0; m_ie[i] = 0; m_st[i] = 0;
      end
      m_busy = 0; m_berr = 0; m_rc = 0;
    end else begin
      bit h[6];
      bit sv, wf;
      for (int i = 0; i < 6; i++) begin
        bit a;
        a = m_en[i] && (i < 2 ? half_tick : (i == 5 ? m_busy : 1'b1));
        h[i] = a && m_cnt[i] <= 1;
      end
      sv = h[5] && !acc_start && !acc_done;
      wf = h[4] && m_st[4];
      m_berr = sv;
      if (wf) m_rc = RST_LEN; else if (m_rc > 0) m_rc--;
      if (wr_en && addr == 5'b11100)
        for (int i = 0; i < 6; i++) if (wdata[i]) m_st[i] = 0;
      for (int i = 0; i < 5; i++) if (h[i]) m_st[i] = 1;
      if (sv) m_st[5] = 1;
      // surveillance
      if (acc_start) m_cnt[5] = m_rld[5];
      else if (!acc_done && m_en[5] && m_busy) m_cnt[5] = sv ? 0 : m_cnt[5] - 1;
      if (acc_start) m_busy = 1; else if (acc_done || sv) m_busy = 0;
      // general purpose and watchdog
      for (int i = 0; i < 5; i++) begin
        bit a;
        a = m_en[i] && (i < 2 ? half_tick : 1'b1);
        if (a) begin
          if (!h[i]) m_cnt[i]--;
          else if (i == 4 || m_md[i]) m_cnt[i] = m_rld[i];
          else begin m_cnt[i] = 0; m_en[i] = 0; end
        end
      end
      if (wr_en && addr[4:2] < 6) begin
        int k;
        k = addr[4:2];
        if (addr[1:0] == 0) begin m_en[k] = wdata[0]; m_md[k] = wdata[1]; m_ie[k] = wdata[2]; end
        else if (addr[1:0] == 1) begin m_rld[k] = wdata; m_cnt[k] = wdata; end
      end
    end
  end

  function automatic logic [CW-1:0] m_rdata();
    int k;
    k = addr[4:2];
    if (addr == 5'b11100) return {m_st[5], m_st[4], m_st[3], m_st[2], m_st[1], m_st[0]};
    if (k >= 6) return 0;
    case (addr[1:0])
      0: return {m_ie[k], m_md[k], m_en[k]};
      1: return CW'(m_rld[k]);
      2: return CW'(m_cnt[k]);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp, string what);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [5:0] ei;
    for (int i = 0; i < 6; i++) ei[i] = m_st[i] & m_ie[i];
    chk(req, irq, ei, "irq");
    chk(req, cpu_rst, m_rc != 0, "cpu_rst");
    chk(req, bus_err, m_berr, "bus_err");
    chk(req, rdata, m_rdata(), "rdata");
  endtask

  task automatic tick(int n = 1);
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #1;
      if (rst_n) compare();
    end
  endtask

  task automatic wr(logic [4:0] a, logic [CW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired, run hung");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    // R1 reset state
    tick();
    for (int a = 0; a < 32; a++) begin
      addr = 5'(a); #1;
      chk("R1", rdata, 0, "reset register");
    end
    chk("R1", {irq, cpu_rst, bus_err}, 0, "reset outputs");

    // R2 R4 continuous fast timer
    req = "R4";
    wr(5'd9, 3);                // timer 2 reload
    wr(5'd8, 3'b111);           // enable, continuous, irq enable
    addr = 5'd10;
    tick(12);
    req = "R6";
    wr(5'b11100, 16'h0004);
    addr = 5'b11100;
    tick(2);

    // R3 R5 slow one-shot, slow continuous
    req = "R3";
    wr(5'd1, 4); wr(5'd5, 2);
    wr(5'd4, 3'b111);
    wr(5'd0, 3'b101);
    addr = 5'd2;
    for (int i = 0; i < 14; i++) begin half_tick = (i % 3 != 1); tick(); end
    req = "R5";
    addr = 5'd0;
    for (int i = 0; i < 8; i++) begin half_tick = i[0]; tick(); end
    half_tick = 0;
    req = "R6";
    wr(5'b11100, 16'h0003);
    addr = 5'b11100; tick();
    wr(5'd8, 3'b000);

    // R11 write colliding with count update
    req = "R11";
    wr(5'd13, 2); wr(5'd12, 3'b011);
    wr(5'd13, 9);
    addr = 5'd14; tick(4);
    wr(5'd12, 0);

    // R7 R8 watchdog
    req = "R8";
    wr(5'd17, 5); wr(5'd16, 3'b100 | 3'b001);
    addr = 5'b11100;
    tick(6);
    wr(5'b11100, 16'h0010);     // service
    tick(6);
    req = "R7";
    tick(12);
    wr(5'd16, 0);
    wr(5'b11100, 16'h003f);

    // R9 R10 surveillance
    req = "R9";
    wr(5'd21, 6); wr(5'd20, 3'b101);
    addr = 5'd22;
    acc_start = 1; tick(); acc_start = 0;
    tick(3);
    acc_done = 1; tick(); acc_done = 0;
    tick(3);
    acc_start = 1; acc_done = 1; tick(); acc_start = 0; acc_done = 0;
    tick(2);
    acc_start = 1; tick(); acc_start = 0;
    req = "R10";
    tick(10);
    addr = 5'b11100; tick();
    wr(5'd21, 0);
    acc_start = 1; tick(); acc_start = 0;
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule